// File: doc/BRIEF.md
# Boot-Overlay Memory Address Decoder

This block sits between a 24-bit processor address bus and the memory system. It sorts every access into one of six targets (RAM, ROM, a parallel-interface peripheral, a serial controller, a floppy controller and a spare trap region for a paravirtual disk interface), or flags it as unmapped. It also hands each memory its local offset. Both offsets are formed by ANDing the address with the memory size minus one, so the sizes must be powers of two.

After reset a boot flag places ROM over the low 4 MiB, so the processor fetches its reset vectors from ROM. While the flag is set, writes into that low window still go to RAM. Boot code jumps to the permanent ROM copy at 0x400000 and then clears the flag. It does this by writing one bit of an output register in the parallel peripheral, and the block watches for that write. From the next access on, RAM answers at address zero. The installed RAM repeats across its whole 4 MiB window, so a size probe can find where the data wraps.

Top module: `mem_map_decoder`

## Requirements
- R1: While rst_ni is low and after it rises, the boot overlay is active until a write changes it.
- R2: With the overlay active, a read at 0x000000–0x3FFFFF selects ROM (sel_o bit 1), and rom_addr_o equals the address ANDed with ROM_SIZE-1.
- R3: With the overlay active, a write at 0x000000–0x3FFFFF selects RAM (sel_o bit 0) and never ROM.
- R4: With the overlay cleared, reads and writes at 0x000000–0x3FFFFF select RAM.
- R5: Addresses 0x400000–0x4FFFFF select ROM whatever the overlay state. The ROM image repeats every ROM_SIZE bytes in that range.
- R6: A write to the overlay control register (address 0xE1FE00) loads the overlay flag from wdata_i bit 4 (1 = active). The new state applies to the very next access.
- R7: ram_addr_o equals the address ANDed with RAM_SIZE-1, so addresses that differ only above that mask reach the same RAM word.
- R8: Peripheral regions are decoded from address bits 23:20: 0x9 serial (sel_o bit 3), 0xC trap (bit 5), 0xD floppy (bit 4), 0xE parallel (bit 2). A requested access drives exactly one of sel_o and unmapped_o.
- R9: Any requested address outside all regions raises unmapped_o with sel_o all zero. A read there returns 0xFFFF on rd_data_o. Otherwise rd_data_o passes rd_data_i through.
- R10: With req_i low, sel_o and unmapped_o are all zero.
- R11: Writes to other addresses, reads of the control register, and idle cycles leave the overlay state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access valid this cycle |
| we_i | input | 1 | Access is a write |
| addr_i | input | 24 | Byte address |
| wdata_i | input | 16 | Write data (bit 4 carries the overlay flag) |
| rd_data_i | input | 16 | Read data returned by the selected target |
| sel_o | output | 6 | One-hot target select: 0 RAM, 1 ROM, 2 parallel, 3 serial, 4 floppy, 5 trap |
| unmapped_o | output | 1 | Access matches no region |
| ram_addr_o | output | 17 | Masked RAM offset |
| rom_addr_o | output | 17 | Masked ROM offset |
| rd_data_o | output | 16 | Read data to the processor |

## Verification
The clocked properties assume that req_i, we_i, addr_i and wdata_i are stable from one falling edge to the next, and that they carry defined values whenever reset is released. The overlay properties also assume that reset is not released in the same cycle as a control-register write. The bench changes inputs only at falling edges and holds req_i low through reset. It toggles the overlay only with complete writes to the exact control address, and it changes other parallel-peripheral offsets to show that they do not affect the flag.

// File: rtl/mmap_pkg.sv
package mmap_pkg;
  localparam int ADDR_W = 24;
  localparam int NREG   = 6;

  typedef enum logic [2:0] {
    RG_RAM  = 3'd0,
    RG_ROM  = 3'd1,
    RG_PIO  = 3'd2,
    RG_SER  = 3'd3,
    RG_DSK  = 3'd4,
    RG_TRP  = 3'd5,
    RG_NONE = 3'd6
  } region_e;

  // region codes on addr[23:20]
  localparam logic [3:0] NIB_RAM_LAST = 4'h3;
  localparam logic [3:0] NIB_ROM      = 4'h4;
  localparam logic [3:0] NIB_SER      = 4'h9;
  localparam logic [3:0] NIB_TRP      = 4'hC;
  localparam logic [3:0] NIB_DSK      = 4'hD;
  localparam logic [3:0] NIB_PIO      = 4'hE;
endpackage

// File: rtl/region_dec.sv
module region_dec
  import mmap_pkg::*;
(
  input  logic [3:0] nib_i,
  input  logic       ovl_i,
  input  logic       we_i,
  output region_e    region_o
);
  always_comb begin
    if (nib_i <= NIB_RAM_LAST) begin
      // overlay steers reads only; writes always land in RAM
      region_o = (ovl_i && !we_i) ? RG_ROM : RG_RAM;
    end else begin
      case (nib_i)
        NIB_ROM: region_o = RG_ROM;
        NIB_SER: region_o = RG_SER;
        NIB_TRP: region_o = RG_TRP;
        NIB_DSK: region_o = RG_DSK;
        NIB_PIO: region_o = RG_PIO;
        default: region_o = RG_NONE;
      endcase
    end
  end
endmodule

// File: rtl/addr_mask.sv
module addr_mask #(
  parameter int AW   = 24,
  parameter int SIZE = 131072,
  localparam int OW  = $clog2(SIZE)
) (
  input  logic [AW-1:0] addr_i,
  output logic [OW-1:0] off_o
);
  localparam logic [AW-1:0] MASK = AW'(SIZE - 1);

  logic [AW-1:0] masked;
  logic          unused_hi;

  assign masked    = addr_i & MASK;
  assign off_o     = masked[OW-1:0];
  assign unused_hi = |masked[AW-1:OW];
endmodule

// File: rtl/ovl_ctrl.sv
module ovl_ctrl #(
  parameter int                AW       = 24,
  parameter logic [AW-1:0]     REG_ADDR = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic          bit_i,
  output logic          ovl_o
);
  logic hit;
  logic ovl_q;

  assign hit   = req_i && we_i && (addr_i == REG_ADDR);
  assign ovl_o = ovl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  ovl_q <= 1'b1;
    else if (hit) ovl_q <= bit_i;
  end

  AST_OVL_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> ovl_q) else $error("overlay not set after reset"); // R1

  AST_OVL_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(hit)) |-> (ovl_q == $past(bit_i))) else $error("overlay did not load"); // R6

  AST_OVL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(hit)) |-> $stable(ovl_q)) else $error("overlay changed without write"); // R11
endmodule

// File: rtl/mem_map_decoder.sv
module mem_map_decoder
  import mmap_pkg::*;
#(
  parameter int          RAM_SIZE   = 131072,
  parameter int          ROM_SIZE   = 131072,
  parameter int          DW         = 16,
  parameter int          OVL_BIT    = 4,
  parameter logic [19:0] OUTREG_OFS = 20'h1FE00
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_i,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DW-1:0]               wdata_i,
  input  logic [DW-1:0]               rd_data_i,
  output logic [NREG-1:0]             sel_o,
  output logic                        unmapped_o,
  output logic [$clog2(RAM_SIZE)-1:0] ram_addr_o,
  output logic [$clog2(ROM_SIZE)-1:0] rom_addr_o,
  output logic [DW-1:0]               rd_data_o
);
  localparam logic [ADDR_W-1:0] OUTREG_ADDR = {NIB_PIO, OUTREG_OFS};

  initial begin
    assert ((RAM_SIZE & (RAM_SIZE - 1)) == 0 && (ROM_SIZE & (ROM_SIZE - 1)) == 0)
      else $error("memory sizes must be powers of two"); // R7
  end

  logic    ovl;
  region_e region;
  logic    unused_wdata;

  assign unused_wdata = ^{wdata_i[DW-1:OVL_BIT+1], wdata_i[OVL_BIT-1:0]};

  ovl_ctrl #(
    .AW       (ADDR_W),
    .REG_ADDR (OUTREG_ADDR)
  ) u_ovl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .we_i   (we_i),
    .addr_i (addr_i),
    .bit_i  (wdata_i[OVL_BIT]),
    .ovl_o  (ovl)
  );

  region_dec u_dec (
    .nib_i    (addr_i[ADDR_W-1 -: 4]),
    .ovl_i    (ovl),
    .we_i     (we_i),
    .region_o (region)
  );

  addr_mask #(.AW(ADDR_W), .SIZE(RAM_SIZE)) u_ram_mask (
    .addr_i (addr_i),
    .off_o  (ram_addr_o)
  );

  addr_mask #(.AW(ADDR_W), .SIZE(ROM_SIZE)) u_rom_mask (
    .addr_i (addr_i),
    .off_o  (rom_addr_o)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_sel
    assign sel_o[i] = req_i && (region == region_e'(i));
  end

  assign unmapped_o = req_i && (region == RG_NONE);
  assign rd_data_o  = (unmapped_o && !we_i) ? '1 : rd_data_i;

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> (sel_o == '0 && !unmapped_o)) else $error("select while idle"); // R10

  AST_ONE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> $onehot({sel_o, unmapped_o})) else $error("not exactly one target"); // R8

  AST_LOW_WR_RAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i[ADDR_W-1 -: 2] == 2'b00) |-> sel_o[int'(RG_RAM)]) else $error("low write missed RAM"); // R3

  AST_ROM_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i[ADDR_W-1 -: 4] == NIB_ROM) |-> sel_o[int'(RG_ROM)]) else $error("high ROM missed"); // R5
endmodule

// File: tb/mem_map_decoder_tb.sv
module mem_map_decoder_tb;
  typedef struct {
    string       tag;
    logic [5:0]  sel;
    logic        unm;
    logic [16:0] ram;
    logic [16:0] rom;
    logic [15:0] rd;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [23:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rd_data_i = '0;
  logic [5:0]  sel_o;
  logic        unmapped_o;
  logic [16:0] ram_addr_o;
  logic [16:0] rom_addr_o;
  logic [15:0] rd_data_o;

  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 0;
  bit   ovl_m = 1;
  exp_t q[$];
  event ev_chk;

  logic [16:0] mem_a[$];
  logic [15:0] mem_d[$];

  always #5 clk_i = ~clk_i;

  mem_map_decoder u_dut (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rd_data_i,
    .sel_o, .unmapped_o, .ram_addr_o, .rom_addr_o, .rd_data_o
  );

  function automatic logic [15:0] mem_rd(logic [16:0] a);
    logic [15:0] d = 16'h0000;
    for (int i = 0; i < mem_a.size(); i++) if (mem_a[i] == a) d = mem_d[i];
    return d;
  endfunction

  // driver: drive at falling edge, build expectation from the requirements
  task automatic access(input string tag, input bit rq, input bit wr,
                        input logic [23:0] a, input logic [15:0] wd,
                        input logic [15:0] ram_exp);
    exp_t e;
    logic [3:0] nib = a[23:20];
    @(negedge clk_i);
    req_i = rq; we_i = wr; addr_i = a; wdata_i = wd;
    e.tag = tag;
    e.sel = '0; e.unm = 0;
    if (rq) begin
      if (nib <= 4'h3)       e.sel[(ovl_m && !wr) ? 1 : 0] = 1'b1;
      else if (nib == 4'h4)  e.sel[1] = 1'b1;
      else if (nib == 4'hE)  e.sel[2] = 1'b1;
      else if (nib == 4'h9)  e.sel[3] = 1'b1;
      else if (nib == 4'hD)  e.sel[4] = 1'b1;
      else if (nib == 4'hC)  e.sel[5] = 1'b1;
      else                   e.unm = 1'b1;
    end
    e.ram = a[16:0];
    e.rom = a[16:0];
    #1;
    // stub target memory behind the RAM select
    rd_data_i = (sel_o[0] && !wr) ? mem_rd(ram_addr_o) : 16'hC3C3;
    if (e.unm && !wr)             e.rd = 16'hFFFF;
    else if (e.sel[0] && !wr)     e.rd = ram_exp;
    else                          e.rd = 16'hC3C3;
    if (sel_o[0] && wr) begin mem_a.push_back(ram_addr_o); mem_d.push_back(wd); end
    q.push_back(e);
    -> ev_chk;
    if (rq && wr && a == 24'hE1FE00) ovl_m = wd[4];
    @(posedge clk_i);
  endtask

  // monitor: pop and compare
  initial begin
    exp_t e;
    forever begin
      @(ev_chk);
      e = q.pop_front();
      n_run++;
      if (sel_o !== e.sel || unmapped_o !== e.unm || ram_addr_o !== e.ram ||
          rom_addr_o !== e.rom || rd_data_o !== e.rd) begin
        n_fail++;
        $display("FAIL %s: sel=%b unm=%b ram=%h rom=%h rd=%h expected sel=%b unm=%b ram=%h rom=%h rd=%h",
                 e.tag, sel_o, unmapped_o, ram_addr_o, rom_addr_o, rd_data_o,
                 e.sel, e.unm, e.ram, e.rom, e.rd);
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    access("R10 idle after reset", 0, 0, 24'h000000, 16'h0, 16'h0);
    access("R1 R2 read 0 hits ROM", 1, 0, 24'h000000, 16'h0, 16'h0);
    access("R2 read top of low window", 1, 0, 24'h3FFFFE, 16'h0, 16'h0);
    access("R3 overlay write goes to RAM", 1, 1, 24'h000010, 16'h1111, 16'h0);
    access("R5 ROM base", 1, 0, 24'h400000, 16'h0, 16'h0);
    access("R5 ROM mirror top", 1, 0, 24'h4FFFFE, 16'h0, 16'h0);
    access("R9 just above ROM", 1, 0, 24'h500000, 16'h0, 16'h0);
    access("R9 below serial", 1, 0, 24'h8FFFFF, 16'h0, 16'h0);
    access("R8 serial base", 1, 0, 24'h900000, 16'h0, 16'h0);
    access("R9 above serial", 1, 0, 24'hA00000, 16'h0, 16'h0);
    access("R8 trap base", 1, 0, 24'hC00000, 16'h0, 16'h0);
    access("R8 floppy base", 1, 0, 24'hD00000, 16'h0, 16'h0);
    access("R8 floppy top", 1, 0, 24'hDFFFFF, 16'h0, 16'h0);
    access("R8 parallel base", 1, 0, 24'hE00000, 16'h0, 16'h0);
    access("R9 unmapped write", 1, 1, 24'hF00000, 16'h0, 16'h0);
    access("R9 unmapped top read", 1, 0, 24'hFFFFFF, 16'h0, 16'h0);
    access("R10 idle unmapped addr", 0, 0, 24'hFFFFFF, 16'h0, 16'h0);
    access("R11 other parallel offset", 1, 1, 24'hE1FC00, 16'h0000, 16'h0);
    access("R11 overlay still on", 1, 0, 24'h000000, 16'h0, 16'h0);
    access("R11 read of control reg", 1, 0, 24'hE1FE00, 16'h0, 16'h0);
    access("R11 overlay still on after read", 1, 0, 24'h000002, 16'h0, 16'h0);
    access("R6 set bit keeps overlay", 1, 1, 24'hE1FE00, 16'h0010, 16'h0);
    access("R6 overlay on", 1, 0, 24'h000000, 16'h0, 16'h0);
    access("R6 clear overlay", 1, 1, 24'hE1FE00, 16'hFFEF, 16'h0);
    access("R4 R6 next read 0 is RAM", 1, 0, 24'h000000, 16'h0, 16'h0);
    access("R4 read overlay-time write", 1, 0, 24'h000010, 16'h0, 16'h1111);
    access("R4 top of RAM window", 1, 0, 24'h3FFFFF, 16'h0, 16'h0);
    access("R5 ROM after overlay off", 1, 0, 24'h400000, 16'h0, 16'h0);
    access("R7 write base", 1, 1, 24'h000100, 16'hA5A5, 16'h0);
    access("R7 alias 0x020100", 1, 0, 24'h020100, 16'h0, 16'hA5A5);
    access("R7 alias 0x3E0100", 1, 0, 24'h3E0100, 16'h0, 16'hA5A5);
    access("R7 write high", 1, 1, 24'h3FFF00, 16'h5A5A, 16'h0);
    access("R7 alias 0x01FF00", 1, 0, 24'h01FF00, 16'h0, 16'h5A5A);
    access("R5 ROM mirror offset", 1, 0, 24'h4A1234, 16'h0, 16'h0);
    access("R6 set overlay again", 1, 1, 24'hE1FE00, 16'h0010, 16'h0);
    access("R6 R2 read 0 is ROM again", 1, 0, 24'h000000, 16'h0, 16'h0);
    access("R3 write keeps RAM", 1, 1, 24'h000000, 16'h7777, 16'h0);
    @(negedge clk_i);
    req_i = 0;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule